// File: doc/BRIEF.md
# Inbound Memory Window Translator

This block sits on the inbound side of a PCI host bridge. It holds a small set of memory windows. Each window is described by one configuration word with a 1 MB-aligned PCI base and a logarithmic size code. For every inbound memory address it reports whether the address falls into a window, which window claimed it, and the local system address. Every window maps onto local address zero, so the local address is the offset of the PCI address inside its window.

Software programs the windows through a simple word-wide write port with a combinational read-back. The lookup port takes one 32-bit PCI address per cycle, with no gaps needed between lookups, and returns a registered result one cycle later. Windows are tested in a fixed order, and the lowest-numbered window that matches wins.

Top module: `inbound_win_xlate`

## Requirements
- R1: After reset every window word reads as zero. Each window then spans 0x00000000 to 0x000FFFFF, so address 0x00012345 hits window 0 with local address 0x00012345.
- R2: Window words are at byte offsets 0x50, 0x54 and 0x58 for window indices 0, 1 and 2. A word holds the base in bits 31:20 and the size code in bits 19:16. Bits 15:0 are not stored and read back as zero.
- R3: A write to any offset other than the three window offsets changes no window. A read of such an offset returns zero.
- R4: Size code c gives a window of 2^(20+c) bytes. An address hits when its bits 31:(20+c) equal the same bits of the base.
- R5: Base bits below the window size do not take part in matching or translation. They are still stored and read back unchanged.
- R6: On a hit the local address is the PCI address with all bits from position 20+c upward cleared. This equals the PCI address minus the effective base.
- R7: Size codes 0xC to 0xF disable the window, and it never hits.
- R8: When several windows match, the lowest index is reported.
- R9: A lookup presented with lk_valid in one cycle produces out_valid and its result in the next cycle. out_valid is low in every other cycle.
- R10: A result with no hit reports out_hit=0, out_idx=0 and out_addr=0.
- R11: Size code 0xB gives a 2 GB window, and only address bit 31 is compared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Write strobe for the configuration port |
| reg_addr | input | 8 | Byte offset for writes and reads |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data for reg_addr |
| lk_valid | input | 1 | Lookup request valid |
| lk_addr | input | 32 | Inbound PCI memory address |
| out_valid | output | 1 | Lookup result valid |
| out_hit | output | 1 | Address fell inside a window |
| out_idx | output | 2 | Index of the claiming window |
| out_addr | output | 32 | Translated local address |

## Verification
The bench builds the block with its default parameters: three windows, 32-bit addresses and a 1 MB minimum window. With these values the whole size-code range is reachable. It covers the smallest 1 MB window, the full-width 2 GB window where only bit 31 is compared, and the reserved codes just above it. Three windows are enough to set up overlaps in both directions, so the bench can show the priority order and then show it falling through once the winning window is disabled.

// File: rtl/iwt_pkg.sv
package iwt_pkg;

    localparam int ADDR_W   = 32;
    localparam int MIN_LOG  = 20;
    localparam int CODE_W   = 4;
    localparam int BASE_W   = ADDR_W - MIN_LOG;
    localparam int MAX_CODE = BASE_W - 1;
    localparam int PAD_W    = MIN_LOG - CODE_W;

    typedef logic [ADDR_W-1:0] addr_t;

    typedef struct packed {
        logic [BASE_W-1:0] base;
        logic [CODE_W-1:0] code;
    } win_cfg_t;

    typedef struct packed {
        logic  hit;
        addr_t local_addr;
    } match_t;

    function automatic logic code_ok(logic [CODE_W-1:0] c);
        return int'(c) <= MAX_CODE;
    endfunction

    // ones on every bit that lies inside the window span
    function automatic addr_t span_mask(logic [CODE_W-1:0] c);
        addr_t m;
        for (int i = 0; i < ADDR_W; i++) begin
            m[i] = (i < MIN_LOG + int'(c));
        end
        return m;
    endfunction

    function automatic addr_t base_addr(win_cfg_t w);
        return {w.base, {MIN_LOG{1'b0}}};
    endfunction

    function automatic addr_t pack_word(win_cfg_t w);
        return {w.base, w.code, {PAD_W{1'b0}}};
    endfunction

    function automatic win_cfg_t unpack_word(addr_t d);
        win_cfg_t w;
        w.base = d[ADDR_W-1:MIN_LOG];
        w.code = d[MIN_LOG-1:PAD_W];
        return w;
    endfunction

endpackage

// File: rtl/iwt_win_regs.sv
module iwt_win_regs
    import iwt_pkg::*;
#(
    parameter int NUM_WIN      = 3,
    parameter int OFF_W        = 8,
    parameter int REG_OFF_BASE = 'h50
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      reg_we,
    input  logic [OFF_W-1:0]          reg_addr,
    input  addr_t                     reg_wdata,
    output addr_t                     reg_rdata,
    output win_cfg_t [NUM_WIN-1:0]    cfg
);

    localparam int STRIDE = 4;

    win_cfg_t [NUM_WIN-1:0] cfg_q;
    logic     [NUM_WIN-1:0] sel;
    logic                   any_sel;
    logic                   unused_wbits;

    assign unused_wbits = ^reg_wdata[PAD_W-1:0];

    for (genvar i = 0; i < NUM_WIN; i++) begin : g_win
        localparam logic [OFF_W-1:0] OFF = OFF_W'(REG_OFF_BASE + STRIDE * i);

        assign sel[i] = reg_we && (reg_addr == OFF);

        always_ff @(posedge clk) begin
            if (rst) begin
                cfg_q[i] <= '0;
            end else if (sel[i]) begin
                cfg_q[i] <= unpack_word(reg_wdata);
            end
        end
    end

    assign any_sel = |sel;
    assign cfg     = cfg_q;

    always_comb begin
        reg_rdata = '0;
        for (int i = 0; i < NUM_WIN; i++) begin
            if (reg_addr == OFF_W'(REG_OFF_BASE + STRIDE * i)) begin
                reg_rdata = pack_word(cfg_q[i]);
            end
        end
    end

    AST_CFG_RESET_ZERO: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (cfg_q == '0)); // R1

    AST_STRAY_WRITE_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (reg_we && !any_sel) |=> $stable(cfg_q)); // R3

endmodule

// File: rtl/iwt_win_match.sv
module iwt_win_match
    import iwt_pkg::*;
(
    input  win_cfg_t cfg,
    input  addr_t    addr,
    output match_t   res
);

    addr_t mask;
    addr_t eff_base;
    logic  enabled;
    logic  upper_eq;

    assign mask     = span_mask(cfg.code);
    assign enabled  = code_ok(cfg.code);
    assign eff_base = base_addr(cfg) & ~mask;
    assign upper_eq = ((addr & ~mask) == eff_base);

    assign res.hit        = enabled && upper_eq;
    assign res.local_addr = res.hit ? (addr & mask) : '0;

    always_comb begin
        if (res.hit) begin
            AST_LOCAL_IN_SPAN: assert ((res.local_addr & ~mask) == '0); // R6
        end
    end

endmodule

// File: rtl/iwt_prio_sel.sv
module iwt_prio_sel
    import iwt_pkg::*;
#(
    parameter int NUM_WIN = 3,
    parameter int IDX_W   = 2
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   in_valid,
    input  match_t [NUM_WIN-1:0]   cand,
    output logic                   out_valid,
    output logic                   out_hit,
    output logic [IDX_W-1:0]       out_idx,
    output addr_t                  out_addr
);

    logic             win_hit;
    logic [IDX_W-1:0] win_idx;
    addr_t            win_addr;

    // scan downward so the lowest matching index is left standing
    always_comb begin
        win_hit  = 1'b0;
        win_idx  = '0;
        win_addr = '0;
        for (int i = NUM_WIN - 1; i >= 0; i--) begin
            if (cand[i].hit) begin
                win_hit  = 1'b1;
                win_idx  = IDX_W'(i);
                win_addr = cand[i].local_addr;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_hit   <= 1'b0;
            out_idx   <= '0;
            out_addr  <= '0;
        end else begin
            out_valid <= in_valid;
            out_hit   <= in_valid && win_hit;
            out_idx   <= in_valid ? win_idx : '0;
            out_addr  <= in_valid ? win_addr : '0;
        end
    end

    AST_LOWEST_WINS: assert property (@(posedge clk) disable iff (rst)
        (in_valid && cand[0].hit) |=> (out_hit && out_idx == '0)); // R8

    AST_MISS_ZERO: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_hit) |-> (out_idx == '0 && out_addr == '0)); // R10

    AST_IDX_RANGE: assert property (@(posedge clk) disable iff (rst)
        out_hit |-> (int'(out_idx) < NUM_WIN)); // R8

endmodule

// File: rtl/inbound_win_xlate.sv
module inbound_win_xlate
    import iwt_pkg::*;
#(
    parameter int NUM_WIN      = 3,
    parameter int OFF_W        = 8,
    parameter int REG_OFF_BASE = 'h50
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we,
    input  logic [OFF_W-1:0]  reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              lk_valid,
    input  logic [31:0]       lk_addr,
    output logic              out_valid,
    output logic              out_hit,
    output logic [1:0]        out_idx,
    output logic [31:0]       out_addr
);

    localparam int IDX_W = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1;

    win_cfg_t [NUM_WIN-1:0] cfg;
    match_t   [NUM_WIN-1:0] cand;
    logic     [IDX_W-1:0]   sel_idx;

    iwt_win_regs #(
        .NUM_WIN      (NUM_WIN),
        .OFF_W        (OFF_W),
        .REG_OFF_BASE (REG_OFF_BASE)
    ) u_regs (
        .clk       (clk),
        .rst       (rst),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .cfg       (cfg)
    );

    for (genvar i = 0; i < NUM_WIN; i++) begin : g_match
        iwt_win_match u_match (
            .cfg  (cfg[i]),
            .addr (lk_addr),
            .res  (cand[i])
        );
    end

    iwt_prio_sel #(
        .NUM_WIN (NUM_WIN),
        .IDX_W   (IDX_W)
    ) u_prio (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (lk_valid),
        .cand      (cand),
        .out_valid (out_valid),
        .out_hit   (out_hit),
        .out_idx   (sel_idx),
        .out_addr  (out_addr)
    );

    assign out_idx = 2'(sel_idx);

    AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        lk_valid |=> out_valid); // R9

    AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (rst)
        !lk_valid |=> !out_valid); // R9

    AST_LOCAL_NOT_ABOVE: assert property (@(posedge clk) disable iff (rst)
        (lk_valid) |=> (!out_hit || out_addr <= $past(lk_addr))); // R6

endmodule

// File: tb/sim_inbound_win_xlate.sv
module sim_inbound_win_xlate;

    typedef struct {
        logic        hit;
        logic [1:0]  idx;
        logic [31:0] addr;
        int          cyc;
        string       req;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        lk_valid = 1'b0;
    logic [31:0] lk_addr = '0;
    logic        out_valid;
    logic        out_hit;
    logic [1:0]  out_idx;
    logic [31:0] out_addr;

    int   total = 0;
    int   bad = 0;
    int   cyc = 0;
    bit   done = 1'b0;
    exp_t q[$];
    logic [15:0] shadow [3];

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    inbound_win_xlate u0 (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .lk_valid(lk_valid),
        .lk_addr(lk_addr), .out_valid(out_valid), .out_hit(out_hit),
        .out_idx(out_idx), .out_addr(out_addr)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // independent reference of the window rules
    function automatic exp_t model(input logic [31:0] a, input string req);
        exp_t e;
        e.hit = 1'b0; e.idx = 2'd0; e.addr = 32'd0; e.req = req; e.cyc = 0;
        for (int w = 0; w < 3; w++) begin
            logic [3:0]  c;
            logic [63:0] m;
            logic [31:0] b;
            c = shadow[w][3:0];
            if (c > 4'd11) continue;
            m = (64'd1 << (20 + c)) - 64'd1;
            b = {shadow[w][15:4], 20'd0} & ~m[31:0];
            if ((a & ~m[31:0]) == b) begin
                e.hit = 1'b1; e.idx = 2'(w); e.addr = a & m[31:0];
                break;
            end
        end
        return e;
    endfunction

    task automatic wr(input logic [7:0] off, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = off; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
        for (int w = 0; w < 3; w++)
            if (off == 8'(8'h50 + 4 * w)) shadow[w] = d[31:16];
    endtask

    task automatic rd(input logic [7:0] off, input logic [31:0] exp, input string req);
        @(negedge clk);
        reg_addr = off;
        #1;
        chk(reg_rdata === exp, req, 64'(reg_rdata), 64'(exp));
    endtask

    // present a burst of back-to-back lookups
    task automatic look(input logic [31:0] addrs [], input string req);
        foreach (addrs[k]) begin
            exp_t e;
            @(negedge clk);
            lk_valid = 1'b1; lk_addr = addrs[k];
            e = model(addrs[k], req);
            e.cyc = cyc + 1;
            q.push_back(e);
        end
        @(negedge clk);
        lk_valid = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    // monitor: compare each result as the design produces it
    initial begin
        forever begin
            @(negedge clk);
            if (!rst && out_valid) begin
                if (q.size() == 0) begin
                    chk(1'b0, "R9 unexpected result", 64'(out_addr), 64'd0);
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    chk(cyc == e.cyc, {e.req, " R9 latency"}, 64'(cyc), 64'(e.cyc));
                    chk(out_hit === e.hit && out_idx === e.idx && out_addr === e.addr,
                        e.req, {out_hit, 29'd0, out_idx, out_addr},
                        {e.hit, 29'd0, e.idx, e.addr});
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            chk(1'b0, "watchdog", 64'(cyc), 64'd0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        for (int w = 0; w < 3; w++) shadow[w] = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd(8'h50, 32'h0, "R1 win0 reset");
        rd(8'h54, 32'h0, "R1 win1 reset");
        rd(8'h58, 32'h0, "R1 win2 reset");
        look('{32'h0001_2345, 32'h0010_0000}, "R1 R10 reset lookup");

        // R2 readback drops low half; R4 R6 4 MB window
        wr(8'h50, 32'h1002_ABCD);
        rd(8'h50, 32'h1002_0000, "R2 readback");
        look('{32'h1012_3456, 32'h1040_0000, 32'h0FFF_FFFF}, "R4 R6 4MB window");

        // R4 1 MB window, edges
        wr(8'h54, 32'h2000_0000);
        look('{32'h200F_FFFF, 32'h2010_0000, 32'h2000_0000}, "R4 1MB edges");

        // R5 base bits under the span ignored, still read back
        wr(8'h58, 32'h3053_0000);
        rd(8'h58, 32'h3053_0000, "R5 raw readback");
        look('{32'h3001_2345, 32'h307F_FFFF, 32'h3080_0000}, "R5 low base bits");

        // R8 overlap: window1 inside window0
        wr(8'h54, 32'h1000_0000);
        look('{32'h1005_0000}, "R8 lowest wins");

        // R7 reserved codes disable
        wr(8'h50, 32'h100C_0000);
        look('{32'h1005_0000, 32'h1025_0000}, "R7 code C off");
        wr(8'h50, 32'h100F_0000);
        look('{32'h1025_0000}, "R7 code F off");

        // R11 2 GB window
        wr(8'h58, 32'h800B_0000);
        look('{32'h9ABC_DEF0, 32'h7FFF_FFFF, 32'hFFFF_FFFF}, "R11 2GB");

        // R3 stray writes and reads
        wr(8'h5C, 32'hFFFF_0000);
        wr(8'h4C, 32'hFFFF_0000);
        wr(8'h52, 32'hFFFF_0000);
        rd(8'h50, 32'h100F_0000, "R3 win0 intact");
        rd(8'h54, 32'h1000_0000, "R3 win1 intact");
        rd(8'h58, 32'h800B_0000, "R3 win2 intact");
        rd(8'h5C, 32'h0, "R3 unmapped read");
        look('{32'h1005_0000, 32'h0000_0000}, "R3 lookups unchanged");

        repeat (4) @(negedge clk);
        chk(q.size() == 0, "R9 all results seen", 64'(q.size()), 64'd0);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule